// File: doc/BRIEF.md
# Dual Receive Buffer with Destination Filter

This block is the receive side of a small Ethernet MAC. A frame arrives as a byte stream qualified by a valid strobe and closed by a last flag. The block checks the destination address in the first six bytes and writes each accepted frame into one of two receive buffers. A processor reads those buffers over a 32-bit word-addressed register bus. When a frame has been stored, the block sets that buffer's full flag and can raise a one-cycle interrupt. If alternation is enabled, the next frame goes to the other buffer.

The station address, a global interrupt enable and the alternation enable are plain inputs. Software releases a buffer by writing its control word with the full flag clear. The ready output tells the upstream framer whether the buffer that will take the next frame is free. Bytes are never back-pressured: a frame whose first byte arrives while that buffer is full is discarded whole. CRC checking, preamble removal and the line interface are handled elsewhere.

Top module: `rxpp_top`

## Requirements
- R1: After reset both control words read 0, buffer 0 is selected, `rx_ready_o` is 1, `irq_o` is 0 and `bus_rdata_o` is 0.
- R2: A frame whose first byte has bit 7 set (group address) passes the filter, whatever its other address bytes are.
- R3: A frame whose first byte has bit 7 clear passes only if its first six bytes equal `station_addr_i`, with the first byte compared against bits 47:40 and the sixth against bits 7:0. A frame that fails sets no full flag, raises no interrupt and leaves the selection unchanged.
- R4: A frame that ends before its sixth byte is discarded, with the same lack of effect as in R3.
- R5: Byte k of a stored frame goes to data byte offset k of the selected buffer: word k/4, lane k%4, least significant byte first. Buffer 0 data starts at word address 0x400 and buffer 1 data at 0x600. Bytes at offset 2044 and above are discarded, and the control word is left untouched.
- R6: Storing a frame sets bit 0 (full) of the selected buffer's control word. Buffer 0's control word is at word address 0x5FF and buffer 1's at 0x7FF.
- R7: `irq_o` is high for exactly one cycle, the cycle after the last byte of a stored frame, when bit 3 (interrupt enable) of that buffer's control word and `gie_i` are both 1. Otherwise it stays low.
- R8: After each stored frame the selection toggles if `pingpong_i` is 1, and returns to buffer 0 if it is 0.
- R9: `rx_ready_o` is 1 exactly when the full flag of the selected buffer is clear.
- R10: A frame whose first byte arrives while the selected buffer is full is discarded. The buffer data, the control words, the selection and `irq_o` are unchanged.
- R11: A bus write to a control word stores all 32 bits as given, so a value with bit 0 clear frees the buffer. A read returns the addressed word in `bus_rdata_o` one cycle after `bus_rd_i`, and the value is held until the next read. Bus writes to the data area are ignored. Reads below word address 0x400 return 0.
- R12: If a bus write to a control word lands in the same cycle as the last byte of a frame stored in that buffer, the written value is kept but bit 0 ends up set. The interrupt enable is then taken from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rx_valid_i | input | 1 | A frame byte is present this cycle |
| rx_data_i | input | 8 | Frame byte |
| rx_last_i | input | 1 | This byte ends the frame |
| rx_ready_o | output | 1 | Selected buffer is free |
| station_addr_i | input | 48 | Own station address, first byte in bits 47:40 |
| gie_i | input | 1 | Global interrupt enable |
| pingpong_i | input | 1 | Alternate between the two buffers |
| bus_waddr_i | input | 11 | Register bus word address (byte address / 4) |
| bus_wr_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 32 | Register write data |
| bus_rd_i | input | 1 | Register read strobe |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | One-cycle frame-stored interrupt |

## Verification
The assertions assume that software never sets a full flag through the bus while a frame is being written, since the frame in progress would then land in a buffer marked full. They also assume that `pingpong_i` changes only while buffer 0 is selected, and that frames are at least six bytes apart in commit time. The stimulus frees buffers only between frames and clears `pingpong_i` only after an even number of stored frames. Its single deliberate collision between a bus write and a frame end writes a value with bit 0 clear. A behavioural model built from queues and byte arrays runs alongside the design and is compared with the ready, interrupt and read-data outputs on every cycle.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_LIVE = 2'd1,
        FR_SKIP = 2'd2
    } fr_state_e;

    localparam int CTRL_FULL_BIT = 0;
    localparam int CTRL_IE_BIT   = 3;
    localparam int HDR_BYTES     = 6;

endpackage

// File: rtl/rxpp_addr_filter.sv
module rxpp_addr_filter #(
    parameter int IDX_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [7:0]       byte_i,
    input  logic [47:0]      station_i,
    output logic             pass_o
);
    import rxpp_pkg::*;

    typedef struct packed {
        logic grp;
        logic hit;
    } filt_t;

    filt_t filt_q, filt_d;
    logic [7:0] want_byte;
    logic       in_head;
    logic       cur_hit;
    logic       grp_now;
    logic       hit_now;

    always_comb begin
        in_head = (idx_i < IDX_W'(HDR_BYTES));
        case (idx_i[2:0])
            3'd0:    want_byte = station_i[47:40];
            3'd1:    want_byte = station_i[39:32];
            3'd2:    want_byte = station_i[31:24];
            3'd3:    want_byte = station_i[23:16];
            3'd4:    want_byte = station_i[15:8];
            default: want_byte = station_i[7:0];
        endcase
        cur_hit = (byte_i == want_byte);

        if (idx_i == '0) begin
            grp_now = byte_i[7];
            hit_now = cur_hit;
        end else begin
            grp_now = filt_q.grp;
            hit_now = filt_q.hit & (in_head ? cur_hit : 1'b1);
        end

        filt_d = filt_q;
        if (en_i) begin
            filt_d.grp = grp_now;
            filt_d.hit = hit_now;
        end
        pass_o = grp_now | hit_now;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            filt_q <= '0;
        end else begin
            filt_q <= filt_d;
        end
    end

endmodule

// File: rtl/rxpp_frame_ctl.sv
module rxpp_frame_ctl #(
    parameter int DATA_BYTES = 2044,
    parameter int IDX_W      = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rx_valid_i,
    input  logic             rx_last_i,
    input  logic             sel_full_i,
    input  logic             pass_i,
    output logic             take_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             wr_en_o,
    output logic             commit_o
);
    import rxpp_pkg::*;

    localparam logic [IDX_W-1:0] LIMIT    = IDX_W'(DATA_BYTES);
    localparam logic [IDX_W-1:0] LAST_HDR = IDX_W'(HDR_BYTES - 1);

    typedef struct packed {
        fr_state_e        st;
        logic [IDX_W-1:0] idx;
    } fctl_t;

    fctl_t fc_q, fc_d;

    always_comb begin
        fc_d     = fc_q;
        take_o   = 1'b0;
        wr_en_o  = 1'b0;
        commit_o = 1'b0;

        if (rx_valid_i) begin
            case (fc_q.st)
                FR_IDLE: begin
                    if (sel_full_i) begin
                        if (!rx_last_i) fc_d.st = FR_SKIP;
                    end else begin
                        take_o = 1'b1;
                    end
                end
                FR_LIVE: take_o = 1'b1;
                FR_SKIP: if (rx_last_i) fc_d.st = FR_IDLE;
                default: fc_d.st = FR_IDLE;
            endcase
        end

        if (take_o) begin
            wr_en_o = (fc_q.idx < LIMIT);
            if (fc_q.idx < LAST_HDR) begin
                if (rx_last_i) begin
                    fc_d.st  = FR_IDLE;
                    fc_d.idx = '0;
                end else begin
                    fc_d.st  = FR_LIVE;
                    fc_d.idx = fc_q.idx + 1'b1;
                end
            end else if (fc_q.idx == LAST_HDR && !pass_i) begin
                fc_d.st  = rx_last_i ? FR_IDLE : FR_SKIP;
                fc_d.idx = '0;
            end else if (rx_last_i) begin
                commit_o = 1'b1;
                fc_d.st  = FR_IDLE;
                fc_d.idx = '0;
            end else begin
                fc_d.st = FR_LIVE;
                if (fc_q.idx != LIMIT) fc_d.idx = fc_q.idx + 1'b1;
            end
        end

        idx_o = fc_q.idx;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fc_q.st  <= FR_IDLE;
            fc_q.idx <= '0;
        end else begin
            fc_q <= fc_d;
        end
    end

endmodule

// File: rtl/rxpp_buf_store.sv
module rxpp_buf_store #(
    parameter int BUF_BYTES = 2048,
    parameter int IDX_W     = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [7:0]       wr_byte_i,
    input  logic             commit_i,
    input  logic             gie_i,
    input  logic             pingpong_i,
    input  logic [$clog2(BUF_BYTES/4)+1:0] bus_waddr_i,
    input  logic             bus_wr_i,
    input  logic [31:0]      bus_wdata_i,
    input  logic             bus_rd_i,
    output logic [31:0]      bus_rdata_o,
    output logic             sel_full_o,
    output logic             irq_o
);
    import rxpp_pkg::*;

    localparam int WORD_W    = $clog2(BUF_BYTES / 4);
    localparam int AW        = WORD_W + 2;
    localparam int MEM_DEPTH = 2 ** (WORD_W + 1);
    localparam logic [WORD_W-1:0] CTRL_WORD = WORD_W'(BUF_BYTES / 4 - 1);

    typedef struct packed {
        logic [1:0][31:0] ctrl;
        logic             sel;
        logic             irq;
        logic [31:0]      rdata;
    } store_t;

    store_t st_q, st_d;

    logic [3:0][7:0] mem [MEM_DEPTH];

    logic              in_win;
    logic              bus_buf;
    logic [WORD_W-1:0] bus_word;
    logic              is_ctrl;
    logic [3:0][7:0]   rd_word;

    always_comb begin
        in_win   = bus_waddr_i[AW-1];
        bus_buf  = bus_waddr_i[AW-2];
        bus_word = bus_waddr_i[WORD_W-1:0];
        is_ctrl  = (bus_word == CTRL_WORD);
        rd_word  = mem[{bus_buf, bus_word}];

        st_d     = st_q;
        st_d.irq = 1'b0;

        if (bus_rd_i) begin
            if (!in_win)      st_d.rdata = '0;
            else if (is_ctrl) st_d.rdata = st_q.ctrl[bus_buf];
            else              st_d.rdata = rd_word;
        end

        if (bus_wr_i && in_win && is_ctrl) begin
            st_d.ctrl[bus_buf] = bus_wdata_i;
        end

        if (commit_i) begin
            st_d.ctrl[st_q.sel][CTRL_FULL_BIT] = 1'b1;
            st_d.irq = st_d.ctrl[st_q.sel][CTRL_IE_BIT] & gie_i;
            st_d.sel = pingpong_i ? ~st_q.sel : 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (wr_en_i) begin
            mem[{st_q.sel, wr_idx_i[2 +: WORD_W]}][wr_idx_i[1:0]] <= wr_byte_i;
        end
    end

    assign bus_rdata_o = st_q.rdata;
    assign sel_full_o  = st_q.ctrl[st_q.sel][CTRL_FULL_BIT];
    assign irq_o       = st_q.irq;

endmodule

// File: rtl/rxpp_top.sv
module rxpp_top #(
    parameter int BUF_BYTES = 2048
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        rx_valid_i,
    input  logic [7:0]  rx_data_i,
    input  logic        rx_last_i,
    output logic        rx_ready_o,
    input  logic [47:0] station_addr_i,
    input  logic        gie_i,
    input  logic        pingpong_i,
    input  logic [$clog2(BUF_BYTES/4)+1:0] bus_waddr_i,
    input  logic        bus_wr_i,
    input  logic [31:0] bus_wdata_i,
    input  logic        bus_rd_i,
    output logic [31:0] bus_rdata_o,
    output logic        irq_o
);
    localparam int DATA_BYTES = BUF_BYTES - 4;
    localparam int IDX_W      = $clog2(DATA_BYTES + 1);

    logic             take;
    logic [IDX_W-1:0] idx;
    logic             pass;
    logic             wr_en;
    logic             commit;
    logic             sel_full;

    rxpp_addr_filter #(
        .IDX_W (IDX_W)
    ) u_filter (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (take),
        .idx_i     (idx),
        .byte_i    (rx_data_i),
        .station_i (station_addr_i),
        .pass_o    (pass)
    );

    rxpp_frame_ctl #(
        .DATA_BYTES (DATA_BYTES),
        .IDX_W      (IDX_W)
    ) u_fctl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rx_valid_i (rx_valid_i),
        .rx_last_i  (rx_last_i),
        .sel_full_i (sel_full),
        .pass_i     (pass),
        .take_o     (take),
        .idx_o      (idx),
        .wr_en_o    (wr_en),
        .commit_o   (commit)
    );

    rxpp_buf_store #(
        .BUF_BYTES (BUF_BYTES),
        .IDX_W     (IDX_W)
    ) u_store (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (wr_en),
        .wr_idx_i    (idx),
        .wr_byte_i   (rx_data_i),
        .commit_i    (commit),
        .gie_i       (gie_i),
        .pingpong_i  (pingpong_i),
        .bus_waddr_i (bus_waddr_i),
        .bus_wr_i    (bus_wr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rd_i    (bus_rd_i),
        .bus_rdata_o (bus_rdata_o),
        .sel_full_o  (sel_full),
        .irq_o       (irq_o)
    );

    assign rx_ready_o = ~sel_full;

endmodule

// File: rtl/rxpp_sva.sv
module rxpp_sva #(
    parameter int AW = 11
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          irq_o,
    input logic          gie_i,
    input logic          pingpong_i,
    input logic          rx_ready_o,
    input logic          bus_wr_i,
    input logic          bus_rd_i,
    input logic [AW-1:0] bus_waddr_i,
    input logic [31:0]   bus_rdata_o,
    input logic          commit_i,
    input logic          wr_en_i,
    input logic          sel_full_i
);

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |=> !irq_o); // R7

    AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ($past(gie_i) && $past(commit_i))); // R7

    AST_SOLO_MODE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(commit_i) && !$past(pingpong_i)) |-> !rx_ready_o); // R8

    AST_READY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(bus_wr_i) && !$past(commit_i)) |-> $stable(rx_ready_o)); // R9

    AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |-> !sel_full_i); // R10

    AST_RD_OUTSIDE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(bus_rd_i) && !$past(bus_waddr_i[AW-1])) |-> (bus_rdata_o == 32'h0)); // R11

endmodule

bind rxpp_top rxpp_sva #(
    .AW ($clog2(BUF_BYTES/4) + 2)
) u_sva (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_o       (irq_o),
    .gie_i       (gie_i),
    .pingpong_i  (pingpong_i),
    .rx_ready_o  (rx_ready_o),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_waddr_i (bus_waddr_i),
    .bus_rdata_o (bus_rdata_o),
    .commit_i    (commit),
    .wr_en_i     (wr_en),
    .sel_full_i  (sel_full)
);

// File: tb/rxpp_top_tb_top.sv
module rxpp_top_tb_top;

    localparam logic [47:0] MAC = 48'h02_11_22_33_44_55;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h0;
    logic        rx_last = 1'b0;
    logic        gie = 1'b0;
    logic        pp = 1'b0;
    logic [10:0] baddr = 11'h0;
    logic        bwr = 1'b0;
    logic [31:0] bwdata = 32'h0;
    logic        brd = 1'b0;
    logic        rx_ready;
    logic [31:0] brdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    logic [31:0] rv;
    logic [7:0]  fq[$];
    logic [7:0]  long_q[$];

    always #5 clk = ~clk;

    rxpp_top dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last),
        .rx_ready_o(rx_ready), .station_addr_i(MAC),
        .gie_i(gie), .pingpong_i(pp),
        .bus_waddr_i(baddr), .bus_wr_i(bwr), .bus_wdata_i(bwdata),
        .bus_rd_i(brd), .bus_rdata_o(brdata), .irq_o(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_ctrl [2];
    logic        m_sel;
    logic        m_irq;
    logic [31:0] m_rdata;
    logic [7:0]  m_mem [2][2048];
    int          m_mode;
    logic [7:0]  m_frm[$];

    function automatic logic [31:0] m_word(input logic b, input int w);
        return {m_mem[b][4*w+3], m_mem[b][4*w+2], m_mem[b][4*w+1], m_mem[b][4*w]};
    endfunction

    function automatic bit m_addr_ok();
        for (int i = 0; i < 6; i++)
            if (m_frm[i] != MAC[47-8*i -: 8]) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin : model
        logic [31:0] nrd;
        bit cm;
        int n;
        if (!rst_n) begin
            m_ctrl[0] = 0; m_ctrl[1] = 0; m_sel = 0; m_irq = 0;
            m_rdata = 0; m_mode = 0; m_frm.delete();
        end else begin
            nrd = m_rdata;
            if (brd) begin
                if (!baddr[10])               nrd = 0;
                else if (baddr[8:0] == 9'h1FF) nrd = m_ctrl[baddr[9]];
                else                           nrd = m_word(baddr[9], int'(baddr[8:0]));
            end
            cm = 0;
            if (rx_valid) begin
                if (m_mode == 0) begin
                    if (m_ctrl[m_sel][0]) m_mode = 2;
                    else begin m_mode = 1; m_frm.delete(); end
                end
                if (m_mode == 1) begin
                    m_frm.push_back(rx_data);
                    n = m_frm.size();
                    if (n <= 2044) m_mem[m_sel][n-1] = rx_data;
                    if (n == 6 && !(m_frm[0][7] || m_addr_ok())) m_mode = 2;
                    if (rx_last) begin
                        cm = (m_mode == 1) && (n >= 6);
                        m_mode = 0;
                    end
                end else if (rx_last) begin
                    m_mode = 0;
                end
            end
            if (bwr && baddr[10] && baddr[8:0] == 9'h1FF) m_ctrl[baddr[9]] = bwdata;
            m_irq = 0;
            if (cm) begin
                m_ctrl[m_sel][0] = 1'b1;
                m_irq = m_ctrl[m_sel][3] & gie;
                m_sel = pp ? ~m_sel : 1'b0;
            end
            m_rdata = nrd;
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n) begin
            checks += 3;
            if (rx_ready !== ~m_ctrl[m_sel][0]) begin
                errors++;
                $display("FAIL R9 ready actual=%0b expected=%0b t=%0t", rx_ready, ~m_ctrl[m_sel][0], $time);
            end
            if (irq !== m_irq) begin
                errors++;
                $display("FAIL R7 irq actual=%0b expected=%0b t=%0t", irq, m_irq, $time);
            end
            if (brdata !== m_rdata) begin
                errors++;
                $display("FAIL R11 rdata actual=%h expected=%h t=%0t", brdata, m_rdata, $time);
            end
            if (irq) irq_seen++;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [10:0] a, input logic [31:0] v);
        @(posedge clk); #2;
        baddr = a; bwdata = v; bwr = 1'b1;
        @(posedge clk); #2;
        bwr = 1'b0;
    endtask

    task automatic bus_read(input logic [10:0] a, output logic [31:0] v);
        @(posedge clk); #2;
        baddr = a; brd = 1'b1;
        @(posedge clk); #2;
        brd = 1'b0;
        @(negedge clk);
        v = brdata;
    endtask

    task automatic send_frame(input logic [7:0] b[$], input bit clash, input logic [31:0] cval);
        for (int i = 0; i < b.size(); i++) begin
            @(posedge clk); #2;
            rx_valid = 1'b1; rx_data = b[i]; rx_last = (i == b.size() - 1);
            if (clash && i == b.size() - 1) begin
                baddr = 11'h5FF; bwdata = cval; bwr = 1'b1;
            end
        end
        @(posedge clk); #2;
        rx_valid = 1'b0; rx_last = 1'b0; bwr = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic mk_frame(input bit grp, input int len, input logic [7:0] seed);
        fq.delete();
        for (int i = 0; i < len; i++) begin
            if (i < 6) fq.push_back(grp ? (i == 0 ? 8'h81 : 8'h10 + 8'(i)) : MAC[47-8*i -: 8]);
            else       fq.push_back(seed + 8'(i));
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int irq0;
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", {31'b0, rx_ready}, 32'h1);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        check("R1 rdata after reset", brdata, 32'h0);
        bus_read(11'h5FF, rv); check("R1 ctrl0 reset", rv, 32'h0);
        bus_read(11'h7FF, rv); check("R1 ctrl1 reset", rv, 32'h0);

        bus_write(11'h5FF, 32'h8);
        bus_write(11'h7FF, 32'h8);
        gie = 1'b1; pp = 1'b1;

        // R3 exact station match into buffer 0
        irq0 = irq_seen;
        mk_frame(1'b0, 10, 8'hA0);
        send_frame(fq, 1'b0, 32'h0);
        bus_read(11'h5FF, rv); check("R6 ctrl0 full", rv, 32'h9);
        bus_read(11'h400, rv); check("R5 buf0 word0", rv, 32'h33221102);
        bus_read(11'h401, rv); check("R5 buf0 word1", rv, {fq[7], fq[6], fq[5], fq[4]});
        check("R7 irq pulse count", irq_seen - irq0, 1);
        check("R8 toggled to free buffer1", {31'b0, rx_ready}, 32'h1);

        // R2 group frame into buffer 1
        mk_frame(1'b1, 8, 8'h40);
        send_frame(fq, 1'b0, 32'h0);
        bus_read(11'h7FF, rv); check("R6 ctrl1 full", rv, 32'h9);
        bus_read(11'h600, rv); check("R2 buf1 word0", rv, {fq[3], fq[2], fq[1], fq[0]});
        check("R9 ready low with buffer0 full", {31'b0, rx_ready}, 32'h0);

        // R10 drop while full
        irq0 = irq_seen;
        mk_frame(1'b0, 12, 8'h70);
        send_frame(fq, 1'b0, 32'h0);
        bus_read(11'h5FF, rv); check("R10 ctrl0 kept", rv, 32'h9);
        bus_read(11'h401, rv); check("R10 buf0 data kept", rv, {8'hA7, 8'hA6, 8'h55, 8'h44});
        check("R10 no irq", irq_seen - irq0, 0);

        // R11 release buffer 0
        bus_write(11'h5FF, 32'h8);
        bus_read(11'h5FF, rv); check("R11 ctrl0 written", rv, 32'h8);
        check("R9 ready back high", {31'b0, rx_ready}, 32'h1);

        // R3 mismatch discarded
        irq0 = irq_seen;
        mk_frame(1'b0, 10, 8'h20);
        fq[5] = 8'h56;
        send_frame(fq, 1'b0, 32'h0);
        bus_read(11'h5FF, rv); check("R3 mismatch no full", rv, 32'h8);
        check("R3 mismatch no irq", irq_seen - irq0, 0);

        // R4 short frame discarded
        mk_frame(1'b1, 4, 8'h0);
        send_frame(fq, 1'b0, 32'h0);
        bus_read(11'h5FF, rv); check("R4 short no full", rv, 32'h8);

        // R8 single-buffer mode
        bus_write(11'h7FF, 32'h0);
        pp = 1'b0;
        irq0 = irq_seen;
        mk_frame(1'b1, 12, 8'h30);
        send_frame(fq, 1'b0, 32'h0);
        bus_read(11'h5FF, rv); check("R8 buffer0 used (sel unchanged by R3/R4)", rv, 32'h9);
        check("R8 irq on buffer0", irq_seen - irq0, 1);
        check("R8 stays on buffer0, not ready", {31'b0, rx_ready}, 32'h0);
        bus_write(11'h5FF, 32'h12345670);
        bus_read(11'h5FF, rv); check("R11 stored as given", rv, 32'h12345670);
        irq0 = irq_seen;
        mk_frame(1'b1, 9, 8'h90);
        send_frame(fq, 1'b0, 32'h0);
        bus_read(11'h5FF, rv); check("R8 buffer0 again", rv, 32'h12345671);
        bus_read(11'h7FF, rv); check("R8 buffer1 untouched", rv, 32'h0);
        check("R7 no irq without enable bit", irq_seen - irq0, 0);

        // R7 global enable off
        bus_write(11'h5FF, 32'h8);
        gie = 1'b0;
        irq0 = irq_seen;
        mk_frame(1'b0, 7, 8'h11);
        send_frame(fq, 1'b0, 32'h0);
        check("R7 no irq with gie low", irq_seen - irq0, 0);
        bus_read(11'h5FF, rv); check("R6 stored with gie low", rv, 32'h9);
        gie = 1'b1;

        // R5 overlong frame
        bus_write(11'h5FF, 32'h8);
        long_q.delete();
        for (int i = 0; i < 2050; i++) long_q.push_back(8'(i * 7 + 1));
        long_q[0] = 8'h81;
        send_frame(long_q, 1'b0, 32'h0);
        bus_read(11'h5FE, rv);
        check("R5 last data word", rv, {long_q[2043], long_q[2042], long_q[2041], long_q[2040]});
        bus_read(11'h5FF, rv); check("R5 ctrl not overrun", rv, 32'h9);

        // R11 data writes ignored, outside reads zero
        bus_write(11'h400, 32'hDEADBEEF);
        bus_read(11'h400, rv);
        check("R11 data write ignored", rv, {long_q[3], long_q[2], long_q[1], long_q[0]});
        bus_read(11'h3FF, rv); check("R11 outside window reads 0", rv, 32'h0);

        // R12 write and frame end together
        bus_write(11'h5FF, 32'h8);
        irq0 = irq_seen;
        mk_frame(1'b1, 6, 8'h0);
        send_frame(fq, 1'b1, 32'h0);
        bus_read(11'h5FF, rv); check("R12 full wins over write", rv, 32'h1);
        check("R12 irq from written enable", irq_seen - irq0, 0);

        repeat (4) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule